// File: doc/BRIEF.md
# NAND Sector Single-Bit ECC Checker and Corrector

This block checks the one-bit Hamming code of one NAND sector after a read and tells the caller what to do about it. It receives the 32-bit parity result that a separate parity engine accumulated over the sector just read. It also receives the 24-bit code that was saved in the spare area when the sector was written. From these it decides whether the sector is clean, holds a single flipped data bit that can be repaired, has damage only inside the stored code, or cannot be repaired.

For a repairable data bit it gives the byte offset inside the sector and a one-hot bit mask. The caller XORs that mask into the byte in its sector buffer. Each check is started by a one-cycle `start` pulse. The verdict comes out on a registered `done` pulse one clock later, together with a two-bit status code. Computing the parity over the data stream, NAND bus timing and the spare-area layout are outside this block.

Top module: `hecc_sector_fix`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, every output is driven to zero after that edge.
- R2: `done` is high in the cycle that follows a cycle where `start` was sampled high, and is low in every other cycle.
- R3: The computed code is the bitwise inverse of {raw[27:16], raw[11:0]}. Raw bits 31:28 and 15:12 have no effect on any output.
- R4: The stored code takes its least significant byte from `stored_ecc[7:0]`. An erased sector, with a raw parity of zero and a stored code of 0xFFFFFF, gives status 0 (pass).
- R5: When the computed code equals the stored code, status is 0 (pass), `fix_valid` is low, and `fix_byte_addr` and `fix_mask` are zero.
- R6: Let the difference be stored XOR computed. When its upper 12 bits XOR its lower 12 bits equal 0xFFF and the byte index is in range, status is 1 (corrected) and `fix_valid` pulses with `done`. `fix_byte_addr` is difference[23:15] and `fix_mask` is 1 shifted left by difference[14:12].
- R7: When the R6 pattern appears but difference[23:15] is at or above `SECTOR_BYTES`, status is 2 (uncorrectable), `fix_valid` stays low, and address and mask are zero.
- R8: A difference with exactly one bit set, meaning an error inside the stored code, gives status 1 with `fix_valid` low and address and mask zero.
- R9: Any other nonzero difference, such as two flipped data bits, gives status 2 with `fix_valid` low and address and mask zero.
- R10: `status`, `fix_byte_addr` and `fix_mask` keep their last value in cycles without a result. `fix_valid` is high only in a `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Sample the code inputs and evaluate them |
| raw_ecc | input | 32 | Parity result word with reserved nibbles at 31:28 and 15:12 |
| stored_ecc | input | 24 | Code read from the spare area, first byte in bits 7:0 |
| done | output | 1 | One-cycle pulse marking a fresh verdict |
| status | output | 2 | 0 pass, 1 corrected, 2 uncorrectable |
| fix_valid | output | 1 | Pulses with `done` when a data bit must be flipped |
| fix_byte_addr | output | 9 | Byte offset of the bit to flip |
| fix_mask | output | 8 | One-hot mask to XOR into that byte |

## Verification
Every result is due exactly one clock edge after the edge that samples `start`. A missing, late or stretched `done` is therefore visible at once, and so is a `fix_valid` outside a `done` cycle. The bench drives inputs on the falling edge. A behavioural model updates its expected outputs on the same rising edge as the design, and both are compared 1 ns after every rising edge, including idle cycles, where the held values are checked. A second instance with a shorter sector runs in parallel, so that the bound on the byte index can be reached.

// File: rtl/hecc_pkg.sv
// Shared types for the sector single-bit ECC checker.
// Assumes a two-bit status code that callers decode directly.
package hecc_pkg;
    typedef enum logic [1:0] {
        HECC_PASS  = 2'd0,
        HECC_FIXED = 2'd1,
        HECC_FAIL  = 2'd2
    } hecc_status_e;
endpackage

// File: rtl/hecc_code_diff.sv
// Packs the raw parity word into the code layout, inverts it, and XORs it
// with the stored code.
// Assumes each half of the code sits at the bottom of a SLOT_W-bit slot in
// the raw word. The bits above HALF_W in each slot are reserved.
module hecc_code_diff #(
    parameter int HALF_W = 12,
    parameter int SLOT_W = 16,
    localparam int RAW_W  = 2 * SLOT_W,
    localparam int CODE_W = 2 * HALF_W
) (
    input  logic [RAW_W-1:0]  raw_word,
    input  logic [CODE_W-1:0] stored_code,
    output logic [CODE_W-1:0] diff
);
    logic [CODE_W-1:0] packed_code;

    // Drop the reserved nibbles and invert, so an erased sector matches all-ones.
    always_comb begin
        packed_code = ~{raw_word[SLOT_W+HALF_W-1:SLOT_W], raw_word[HALF_W-1:0]};
        diff        = packed_code ^ stored_code;
    end
endmodule

// File: rtl/hecc_bit_mask.sv
// Decodes a bit index into a one-hot mask that can be XORed into a byte.
// Assumes the index is always within the mask width.
module hecc_bit_mask #(
    parameter int IDX_W = 3,
    localparam int MASK_W = 1 << IDX_W
) (
    input  logic [IDX_W-1:0]  bit_idx,
    output logic [MASK_W-1:0] mask
);
    for (genvar g = 0; g < MASK_W; g++) begin : g_dec
        // One decoder line per mask bit.
        assign mask[g] = (bit_idx == IDX_W'(g));
    end
endmodule

// File: rtl/hecc_classify.sv
// Classifies a code difference as pass, data-bit repair, stored-code error
// or uncorrectable, and forms the repair address and mask.
// Assumes a data-bit error gives complementary halves, with the upper half
// holding the failing bit address.
module hecc_classify
    import hecc_pkg::*;
#(
    parameter int HALF_W       = 12,
    parameter int BIT_IDX_W    = 3,
    parameter int SECTOR_BYTES = 512,
    localparam int CODE_W = 2 * HALF_W,
    localparam int BYTE_W = HALF_W - BIT_IDX_W,
    localparam int MASK_W = 1 << BIT_IDX_W
) (
    input  logic [CODE_W-1:0] diff,
    output hecc_status_e      verdict,
    output logic              repair,
    output logic [BYTE_W-1:0] repair_byte,
    output logic [MASK_W-1:0] repair_mask
);
    logic              is_clean;
    logic              is_data_err;
    logic              is_code_err;
    logic              in_range;
    logic [BYTE_W-1:0] byte_idx;
    logic [MASK_W-1:0] decoded;

    hecc_bit_mask #(.IDX_W(BIT_IDX_W)) u_mask (
        .bit_idx (diff[HALF_W+BIT_IDX_W-1:HALF_W]),
        .mask    (decoded)
    );

    // Recognise the three difference patterns and the byte bound.
    always_comb begin
        is_clean    = (diff == '0);
        is_data_err = ((diff[CODE_W-1:HALF_W] ^ diff[HALF_W-1:0]) == {HALF_W{1'b1}});
        is_code_err = !is_clean && ((diff & (diff - CODE_W'(1))) == '0);
        byte_idx    = diff[CODE_W-1:HALF_W+BIT_IDX_W];
        in_range    = (32'(byte_idx) < SECTOR_BYTES);
    end

    // Pick the verdict in priority order and gate the repair outputs.
    always_comb begin
        repair      = 1'b0;
        repair_byte = '0;
        repair_mask = '0;
        if (is_clean) begin
            verdict = HECC_PASS;
        end else if (is_data_err) begin
            if (in_range) begin
                verdict     = HECC_FIXED;
                repair      = 1'b1;
                repair_byte = byte_idx;
                repair_mask = decoded;
            end else begin
                verdict = HECC_FAIL;
            end
        end else if (is_code_err) begin
            verdict = HECC_FIXED;
        end else begin
            verdict = HECC_FAIL;
        end
    end
endmodule

// File: rtl/hecc_sector_fix.sv
// Top of the sector single-bit ECC checker and corrector. A start pulse
// samples the raw parity word and the stored code. One clock later the
// verdict appears with a done pulse.
// Assumes a synchronous active-low reset. The verdict fields hold between
// checks, and fix_valid is a pulse.
module hecc_sector_fix
    import hecc_pkg::*;
#(
    parameter int HALF_W       = 12,
    parameter int SLOT_W       = 16,
    parameter int BIT_IDX_W    = 3,
    parameter int SECTOR_BYTES = 512,
    localparam int RAW_W  = 2 * SLOT_W,
    localparam int CODE_W = 2 * HALF_W,
    localparam int BYTE_W = HALF_W - BIT_IDX_W,
    localparam int MASK_W = 1 << BIT_IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RAW_W-1:0]  raw_ecc,
    input  logic [CODE_W-1:0] stored_ecc,
    output logic              done,
    output logic [1:0]        status,
    output logic              fix_valid,
    output logic [BYTE_W-1:0] fix_byte_addr,
    output logic [MASK_W-1:0] fix_mask
);
    logic [CODE_W-1:0] diff;
    hecc_status_e      verdict;
    logic              repair;
    logic [BYTE_W-1:0] repair_byte;
    logic [MASK_W-1:0] repair_mask;

    hecc_code_diff #(.HALF_W(HALF_W), .SLOT_W(SLOT_W)) u_diff (
        .raw_word    (raw_ecc),
        .stored_code (stored_ecc),
        .diff        (diff)
    );

    hecc_classify #(
        .HALF_W       (HALF_W),
        .BIT_IDX_W    (BIT_IDX_W),
        .SECTOR_BYTES (SECTOR_BYTES)
    ) u_cls (
        .diff        (diff),
        .verdict     (verdict),
        .repair      (repair),
        .repair_byte (repair_byte),
        .repair_mask (repair_mask)
    );

    // Register the verdict on start; hold the fields, pulse done and fix_valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done          <= 1'b0;
            status        <= 2'd0;
            fix_valid     <= 1'b0;
            fix_byte_addr <= '0;
            fix_mask      <= '0;
        end else begin
            done      <= start;
            fix_valid <= start && repair;
            if (start) begin
                status        <= verdict;
                fix_byte_addr <= repair_byte;
                fix_mask      <= repair_mask;
            end
        end
    end
endmodule

// File: rtl/hecc_sector_fix_chk.sv
// Temporal checks on the ports of hecc_sector_fix, attached with bind.
module hecc_sector_fix_chk #(
    parameter int SECTOR_BYTES = 512,
    parameter int BYTE_W       = 9,
    parameter int MASK_W       = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              done,
    input logic [1:0]        status,
    input logic              fix_valid,
    input logic [BYTE_W-1:0] fix_byte_addr,
    input logic [MASK_W-1:0] fix_mask
);
    a_r2_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    a_r2_done_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start));
    a_r10_fix_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        fix_valid |-> (done && status == 2'd1));
    a_r6_mask_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        fix_valid |-> ($countones(fix_mask) == 1));
    a_r7_addr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fix_valid |-> (32'(fix_byte_addr) < SECTOR_BYTES));
    a_r5_pass_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 2'd0) |-> (fix_mask == '0 && fix_byte_addr == '0));
    a_r10_hold_status: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(status));
    a_r9_legal_status: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'd3);
endmodule

bind hecc_sector_fix hecc_sector_fix_chk #(
    .SECTOR_BYTES (SECTOR_BYTES),
    .BYTE_W       (BYTE_W),
    .MASK_W       (MASK_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .done          (done),
    .status        (status),
    .fix_valid     (fix_valid),
    .fix_byte_addr (fix_byte_addr),
    .fix_mask      (fix_mask)
);

// File: tb/test_hecc_sector_fix.sv
`timescale 1ns/1ps
module test_hecc_sector_fix;
    localparam int NBYTES = 512;
    localparam int SHORT  = 384;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] raw_ecc = '0;
    logic [23:0] stored_ecc = '0;
    logic        done, fix_valid, s_done, s_fix_valid;
    logic [1:0]  status, s_status;
    logic [8:0]  fix_byte_addr, s_fix_byte_addr;
    logic [7:0]  fix_mask, s_fix_mask;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";

    // Planned verdicts for the current start, for the full and the short sector.
    logic [1:0] p_st, ps_st;
    logic       p_v, ps_v;
    logic [8:0] p_a, ps_a;
    logic [7:0] p_m, ps_m;
    // Model outputs.
    logic       m_done, m_v, ms_v;
    logic [1:0] m_st, ms_st;
    logic [8:0] m_a, ms_a;
    logic [7:0] m_m, ms_m;

    logic [7:0] sector [NBYTES];

    always #2.5 clk = ~clk;

    hecc_sector_fix i_hecc_sector_fix (
        .clk(clk), .rst_n(rst_n), .start(start), .raw_ecc(raw_ecc),
        .stored_ecc(stored_ecc), .done(done), .status(status),
        .fix_valid(fix_valid), .fix_byte_addr(fix_byte_addr), .fix_mask(fix_mask));

    hecc_sector_fix #(.SECTOR_BYTES(SHORT)) i_hecc_sector_fix_short (
        .clk(clk), .rst_n(rst_n), .start(start), .raw_ecc(raw_ecc),
        .stored_ecc(stored_ecc), .done(s_done), .status(s_status),
        .fix_valid(s_fix_valid), .fix_byte_addr(s_fix_byte_addr), .fix_mask(s_fix_mask));

    // Reference model: one register stage, results held, pulses cleared.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_done <= 0; m_v <= 0; ms_v <= 0;
            m_st <= 0; ms_st <= 0; m_a <= 0; ms_a <= 0; m_m <= 0; ms_m <= 0;
        end else begin
            m_done <= start;
            m_v    <= start ? p_v : 1'b0;
            ms_v   <= start ? ps_v : 1'b0;
            if (start) begin
                m_st <= p_st; m_a <= p_a; m_m <= p_m;
                ms_st <= ps_st; ms_a <= ps_a; ms_m <= ps_m;
            end
        end
    end

    task automatic cmp(string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    // Compare both instances with the model on every clock.
    always @(posedge clk) begin
        #1;
        cmp(cur_req == "R1" ? "done" : "done(R2)", int'(done), int'(m_done));
        cmp("done_short(R2)", int'(s_done), int'(m_done));
        cmp("status", int'(status), int'(m_st));
        cmp("fix_valid", int'(fix_valid), int'(m_v));
        cmp("fix_byte_addr", int'(fix_byte_addr), int'(m_a));
        cmp("fix_mask", int'(fix_mask), int'(m_m));
        cmp("status_short", int'(s_status), int'(ms_st));
        cmp("fix_valid_short", int'(s_fix_valid), int'(ms_v));
        cmp("fix_byte_addr_short", int'(s_fix_byte_addr), int'(ms_a));
        cmp("fix_mask_short", int'(s_fix_mask), int'(ms_m));
    end

    // Parity over the sector: even halves in 11:0, odd halves in 27:16.
    function automatic logic [31:0] parity_word(logic [7:0] junk);
        logic [11:0] ev = '0, od = '0;
        for (int b = 0; b < NBYTES; b++)
            for (int i = 0; i < 8; i++)
                if (sector[b][i]) begin
                    int adr = b * 8 + i;
                    for (int k = 0; k < 12; k++)
                        if ((adr >> k) & 1) od[k] = ~od[k]; else ev[k] = ~ev[k];
                end
        return {junk[7:4], od, junk[3:0], ev};
    endfunction

    function automatic logic [23:0] code_of(logic [31:0] raw);
        return ~{raw[27:16], raw[11:0]};
    endfunction

    task automatic fill_random();
        for (int b = 0; b < NBYTES; b++) sector[b] = 8'($urandom);
    endtask

    // Drive one check and then idle cycles where held values are compared.
    task automatic run(string req, logic [31:0] raw, logic [23:0] st,
                       logic [1:0] es, logic ev, logic [8:0] ea, logic [7:0] em,
                       logic [1:0] ss, logic sv, logic [8:0] sa, logic [7:0] sm);
        @(negedge clk);
        cur_req = req;
        raw_ecc = raw; stored_ecc = st;
        p_st = es; p_v = ev; p_a = ea; p_m = em;
        ps_st = ss; ps_v = sv; ps_a = sa; ps_m = sm;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        raw_ecc = 32'($urandom); stored_ecc = 24'($urandom);
        @(negedge clk);
        cur_req = "R10";
        @(negedge clk);
    endtask

    task automatic data_flip(int byte_i, int bit_i);
        logic [31:0] clean_raw, bad_raw;
        logic [1:0]  ss;
        logic        sv;
        fill_random();
        clean_raw = parity_word(8'($urandom));
        sector[byte_i][bit_i] = ~sector[byte_i][bit_i];
        bad_raw = parity_word(8'($urandom));
        ss = (byte_i >= SHORT) ? 2'd2 : 2'd1;
        sv = (byte_i < SHORT);
        run(byte_i >= SHORT ? "R7" : "R6", bad_raw, code_of(clean_raw),
            2'd1, 1'b1, 9'(byte_i), 8'(1 << bit_i),
            ss, sv, sv ? 9'(byte_i) : 9'd0, sv ? 8'(1 << bit_i) : 8'd0);
    endtask

    initial begin
        p_st = 0; p_v = 0; p_a = 0; p_m = 0; ps_st = 0; ps_v = 0; ps_a = 0; ps_m = 0;
        void'($urandom(7));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R4: erased sector, all ones, stored code all ones.
        for (int b = 0; b < NBYTES; b++) sector[b] = 8'hFF;
        run("R4", parity_word(8'h00), 24'hFFFFFF, 0, 0, 0, 0, 0, 0, 0, 0);
        // R5 and R3: clean random sectors, reserved nibbles filled with junk.
        for (int n = 0; n < 5; n++) begin
            logic [31:0] r;
            fill_random();
            r = parity_word(8'($urandom));
            run(n == 0 ? "R5" : "R3", r, code_of(r), 0, 0, 0, 0, 0, 0, 0, 0);
        end
        // R6: one data bit at the corners and at random places.
        data_flip(0, 0);
        data_flip(383, 7);
        data_flip(511, 7);
        for (int n = 0; n < 6; n++) data_flip(int'($urandom % NBYTES), int'($urandom % 8));
        // R7: beyond the short instance's bound.
        data_flip(384, 0);
        data_flip(450, 3);
        // R8: one bit flipped inside the stored code.
        for (int n = 0; n < 6; n++) begin
            logic [31:0] r;
            fill_random();
            r = parity_word(8'($urandom));
            run("R8", r, code_of(r) ^ (24'd1 << (n * 4 + 1)), 1, 0, 0, 0, 1, 0, 0, 0);
        end
        // R9: two data bits flipped.
        for (int n = 0; n < 5; n++) begin
            logic [31:0] c, r;
            int b1, b2;
            fill_random();
            c = parity_word(8'($urandom));
            b1 = int'($urandom % NBYTES);
            b2 = (b1 + 1 + int'($urandom % 300)) % NBYTES;
            sector[b1][n % 8] = ~sector[b1][n % 8];
            sector[b2][(n + 3) % 8] = ~sector[b2][(n + 3) % 8];
            r = parity_word(8'($urandom));
            run("R9", r, code_of(c), 2, 0, 0, 0, 2, 0, 0, 0);
        end
        // R2: back-to-back starts keep done high.
        @(negedge clk);
        cur_req = "R2";
        raw_ecc = 32'h0; stored_ecc = 24'hFFFFFF;
        p_st = 0; p_v = 0; p_a = 0; p_m = 0; ps_st = 0; ps_v = 0; ps_a = 0; ps_m = 0;
        start = 1'b1;
        repeat (2) @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        // R1: synchronous reset clears outputs after a correction.
        data_flip(10, 2);
        cur_req = "R1";
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule